// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a shared memory port and decides which stores may reach the memory. Each request names an operation (plain read, load-linked, plain write, store-conditional), a byte address and the ID of the hardware context that issued it. A load-linked records a reservation on the 16-byte granule that holds the address, tagged with the issuing context. A store-conditional may write only while its context still holds a reservation on its granule. Every write, conditional or not, removes the reservations that cover the granule it touches.

Requests arrive one at a time on a valid/ready channel. Exactly one cycle after a request is accepted, a registered result appears on a valid/ready result channel. The result carries the write enable for the memory and the conditional-store status. A result that is not taken stays on the outputs unchanged, and `req_ready` stays low until it is taken, so back-pressure on the result channel stalls the request channel.

Top module: `llsc_monitor`

## Requirements
- R1: Matching ignores the low 4 address bits: a store-conditional anywhere in the reserved 16-byte granule succeeds, while one in the next granule fails.
- R2: A store-conditional with no reservation held anywhere fails with `res_we`=0 and `res_sc_ok`=0.
- R3: A plain write (op 2) always gives `res_we`=1 and `res_sc_ok`=0, whether or not reservations exist.
- R4: A plain write into a reserved granule removes that reservation, whichever context made the write, so a later store-conditional by the holder fails.
- R5: A store-conditional (op 3) succeeds (`res_we`=1, `res_sc_ok`=1) only when a reservation on its granule carries its own context ID. A failed one changes no reservation.
- R6: A successful store-conditional removes every reservation on its granule, including those held by other contexts.
- R7: A new load-linked (op 1) from a context replaces that context's earlier reservation.
- R8: With all 4 entries in use, a load-linked from a context that holds none evicts the oldest reservation.
- R9: Plain reads (op 0) and load-linked requests give `res_we`=0 and `res_sc_ok`=0.
- R10: The result is valid exactly one cycle after acceptance. While `res_valid`=1 and `res_ready`=0, the result stays stable and `req_ready`=0.
- R11: Synchronous reset drops all reservations, clears `res_valid` and sets `req_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 read, 1 load-linked, 2 write, 3 store-conditional |
| req_addr | input | AW | Byte address |
| req_ctx | input | CW | Hardware context ID |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_we | output | 1 | Write allowed to reach memory |
| res_sc_ok | output | 1 | Store-conditional succeeded |

## Verification
The case that is hardest to reach from the ports is eviction of the oldest entry. It needs every slot filled by distinct contexts, and then a load-linked from a fifth context that holds no slot. The stimulus fills the table in a known order, adds the extra reservation, and then probes with store-conditionals. The evicted context must fail, and a context that was not evicted must still succeed. Back-pressure is tested by holding `res_ready` low across several cycles after a request has been accepted.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_LL    = 2'd1,
    OP_WRITE = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_match.sv
`timescale 1ns/1ps
// Per-entry comparators: granule hit, context hit and combined hit.
module llsc_match #(
  parameter int N  = 4,
  parameter int GW = 28,
  parameter int CW = 4
) (
  input  logic [N-1:0]         ent_vld,
  input  logic [N-1:0][GW-1:0] ent_gran,
  input  logic [N-1:0][CW-1:0] ent_ctx,
  input  logic [GW-1:0]        q_gran,
  input  logic [CW-1:0]        q_ctx,
  output logic [N-1:0]         gran_hit,
  output logic [N-1:0]         ctx_hit,
  output logic [N-1:0]         own_hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign gran_hit[i] = ent_vld[i] && (ent_gran[i] == q_gran);
    assign ctx_hit[i]  = ent_vld[i] && (ent_ctx[i] == q_ctx);
    assign own_hit[i]  = gran_hit[i] && (ent_ctx[i] == q_ctx);
  end
endmodule

// File: rtl/llsc_victim.sv
`timescale 1ns/1ps
// Slot choice for a new reservation: same context, else free, else oldest.
module llsc_victim #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   ent_vld,
  input  logic [N-1:0]   ctx_hit,
  input  logic [N*N-1:0] older,
  output logic [IW-1:0]  slot
);
  logic [N-1:0] is_oldest;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      is_oldest[i] = 1'b1;
      for (int j = 0; j < N; j++)
        if (j != i && !older[i*N+j]) is_oldest[i] = 1'b0;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    slot  = '0;
    for (int i = 0; i < N; i++)
      if (!found && ctx_hit[i]) begin slot = IW'(i); found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && !ent_vld[i]) begin slot = IW'(i); found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && is_oldest[i]) begin slot = IW'(i); found = 1'b1; end
  end
endmodule

// File: rtl/llsc_table.sv
`timescale 1ns/1ps
// Reservation storage with pairwise age relation.
module llsc_table #(
  parameter int N  = 4,
  parameter int GW = 28,
  parameter int CW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ins_en,
  input  logic [IW-1:0]        ins_slot,
  input  logic [GW-1:0]        ins_gran,
  input  logic [CW-1:0]        ins_ctx,
  input  logic [N-1:0]         clr_mask,
  output logic [N-1:0]         ent_vld,
  output logic [N-1:0][GW-1:0] ent_gran,
  output logic [N-1:0][CW-1:0] ent_ctx,
  output logic [N*N-1:0]       older
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vld[i]  <= 1'b0;
        ent_gran[i] <= '0;
        ent_ctx[i]  <= '0;
      end else if (ins_en && ins_slot == IW'(i)) begin
        ent_vld[i]  <= 1'b1;
        ent_gran[i] <= ins_gran;
        ent_ctx[i]  <= ins_ctx;
      end else if (clr_mask[i]) begin
        ent_vld[i]  <= 1'b0;
      end
    end

    for (genvar j = 0; j < N; j++) begin : g_age
      always_ff @(posedge clk) begin
        if (rst)
          older[i*N+j] <= 1'b0;
        else if (ins_en && ins_slot == IW'(i))
          older[i*N+j] <= 1'b0;
        else if (ins_en && ins_slot == IW'(j))
          older[i*N+j] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int GB = 4,
  localparam int GW = AW - GB,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_ctx,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_we,
  output logic          res_sc_ok
);
  import llsc_pkg::*;

  logic [N-1:0]         tbl_vld;
  logic [N-1:0][GW-1:0] tbl_gran;
  logic [N-1:0][CW-1:0] tbl_ctx;
  logic [N*N-1:0]       tbl_older;
  logic [N-1:0]         gran_hit, ctx_hit, own_hit;
  logic [IW-1:0]        vic_slot;
  logic [GW-1:0]        q_gran;
  logic                 acc, ins_en, nxt_we, nxt_ok;
  logic [N-1:0]         clr_mask;
  llsc_op_e             op;

  assign q_gran    = req_addr[AW-1:GB];
  assign op        = llsc_op_e'(req_op);
  assign req_ready = !res_valid || res_ready;
  assign acc       = req_valid && req_ready;

  llsc_match #(.N(N), .GW(GW), .CW(CW)) u_match (
    .ent_vld(tbl_vld), .ent_gran(tbl_gran), .ent_ctx(tbl_ctx),
    .q_gran(q_gran), .q_ctx(req_ctx),
    .gran_hit(gran_hit), .ctx_hit(ctx_hit), .own_hit(own_hit)
  );

  llsc_victim #(.N(N)) u_vic (
    .ent_vld(tbl_vld), .ctx_hit(ctx_hit), .older(tbl_older), .slot(vic_slot)
  );

  always_comb begin
    ins_en   = 1'b0;
    clr_mask = '0;
    nxt_we   = 1'b0;
    nxt_ok   = 1'b0;
    unique case (op)
      OP_READ:  ;
      OP_LL:    ins_en = acc;
      OP_WRITE: begin
        nxt_we   = 1'b1;
        clr_mask = acc ? gran_hit : '0;
      end
      OP_SC: begin
        nxt_we   = |own_hit;
        nxt_ok   = |own_hit;
        clr_mask = (acc && |own_hit) ? gran_hit : '0;
      end
      default: ;
    endcase
  end

  llsc_table #(.N(N), .GW(GW), .CW(CW)) u_tbl (
    .clk(clk), .rst(rst), .ins_en(ins_en), .ins_slot(vic_slot),
    .ins_gran(q_gran), .ins_ctx(req_ctx), .clr_mask(clr_mask),
    .ent_vld(tbl_vld), .ent_gran(tbl_gran), .ent_ctx(tbl_ctx),
    .older(tbl_older)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_sc_ok <= 1'b0;
    end else if (acc) begin
      res_valid <= 1'b1;
      res_we    <= nxt_we;
      res_sc_ok <= nxt_ok;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [CW-1:0] req_ctx,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_we,
  input logic          res_sc_ok,
  input logic [N-1:0]  tbl_vld
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    acc |=> res_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_we) && $stable(res_sc_ok)));
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !req_ready);
  a_r5_ok_writes: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_sc_ok) |-> res_we);
  a_r2_empty_sc: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd3 && tbl_vld == '0) |=> (!res_we && !res_sc_ok));
  a_r3_write: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd2) |=> (res_we && !res_sc_ok));
  a_r9_nowrite: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_op[1]) |=> (!res_we && !res_sc_ok));
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!res_valid && tbl_vld == '0));

  logic unused_ok;
  assign unused_ok = ^{req_addr, req_ctx};
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(N), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .req_ctx(req_ctx),
  .res_valid(res_valid), .res_ready(res_ready), .res_we(res_we),
  .res_sc_ok(res_sc_ok), .tbl_vld(tbl_vld)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_ctx = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_we, res_sc_ok;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_ctx(req_ctx),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_we(res_we), .res_sc_ok(res_sc_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One request; result checked one cycle after acceptance.
  task automatic xfer(input logic [1:0] op, input logic [31:0] a, input logic [3:0] c,
                      input logic ewe, input logic eok, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_ctx = c;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, res_valid}, 32'd1);
    chk({tag, " we"}, {31'd0, res_we}, {31'd0, ewe});
    chk({tag, " ok"}, {31'd0, res_sc_ok}, {31'd0, eok});
  endtask

  task automatic t_r11_reset();
    xfer(2'd1, 32'h40, 4'd1, 1'b0, 1'b0, "R11 ll");
    do_reset();
    chk("R11 res_valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R11 req_ready after reset", {31'd0, req_ready}, 32'd1);
    xfer(2'd3, 32'h40, 4'd1, 1'b0, 1'b0, "R11 sc after reset");
  endtask

  task automatic t_r2_empty();
    do_reset();
    xfer(2'd3, 32'h1230, 4'd2, 1'b0, 1'b0, "R2 sc empty");
  endtask

  task automatic t_r3_r9();
    do_reset();
    xfer(2'd2, 32'h80, 4'd0, 1'b1, 1'b0, "R3 write empty");
    xfer(2'd0, 32'h80, 4'd0, 1'b0, 1'b0, "R9 read");
    xfer(2'd1, 32'h90, 4'd3, 1'b0, 1'b0, "R9 ll");
    xfer(2'd2, 32'h300, 4'd1, 1'b1, 1'b0, "R3 write nonempty");
    xfer(2'd3, 32'h94, 4'd3, 1'b1, 1'b1, "R3 unrelated write kept reservation");
  endtask

  task automatic t_r1_granule();
    do_reset();
    xfer(2'd1, 32'h1000, 4'd1, 1'b0, 1'b0, "R1 ll");
    xfer(2'd3, 32'h1010, 4'd1, 1'b0, 1'b0, "R1 sc next granule");
    xfer(2'd3, 32'h100F, 4'd1, 1'b1, 1'b1, "R1 sc same granule");
  endtask

  task automatic t_r4_clear();
    do_reset();
    xfer(2'd1, 32'h2000, 4'd1, 1'b0, 1'b0, "R4 ll");
    xfer(2'd2, 32'h2004, 4'd2, 1'b1, 1'b0, "R4 write other ctx");
    xfer(2'd3, 32'h2000, 4'd1, 1'b0, 1'b0, "R4 sc after write");
  endtask

  task automatic t_r5_owner();
    do_reset();
    xfer(2'd1, 32'h3000, 4'd1, 1'b0, 1'b0, "R5 ll");
    xfer(2'd3, 32'h3000, 4'd2, 1'b0, 1'b0, "R5 sc foreign ctx");
    xfer(2'd3, 32'h3008, 4'd1, 1'b1, 1'b1, "R5 sc own ctx");
  endtask

  task automatic t_r6_sweep();
    do_reset();
    xfer(2'd1, 32'h4000, 4'd1, 1'b0, 1'b0, "R6 ll c1");
    xfer(2'd1, 32'h4004, 4'd2, 1'b0, 1'b0, "R6 ll c2");
    xfer(2'd3, 32'h4000, 4'd1, 1'b1, 1'b1, "R6 sc c1");
    xfer(2'd3, 32'h4000, 4'd2, 1'b0, 1'b0, "R6 sc c2 swept");
  endtask

  task automatic t_r7_replace();
    do_reset();
    xfer(2'd1, 32'h5000, 4'd1, 1'b0, 1'b0, "R7 ll A");
    xfer(2'd1, 32'h6000, 4'd1, 1'b0, 1'b0, "R7 ll B");
    xfer(2'd3, 32'h5000, 4'd1, 1'b0, 1'b0, "R7 sc old");
    xfer(2'd3, 32'h6000, 4'd1, 1'b1, 1'b1, "R7 sc new");
  endtask

  task automatic t_r8_evict();
    do_reset();
    for (int i = 0; i < 4; i++)
      xfer(2'd1, 32'h100 * (i + 1), 4'(i), 1'b0, 1'b0, "R8 fill");
    xfer(2'd1, 32'h900, 4'd5, 1'b0, 1'b0, "R8 ll extra");
    xfer(2'd3, 32'h100, 4'd0, 1'b0, 1'b0, "R8 oldest evicted");
    xfer(2'd3, 32'h200, 4'd1, 1'b1, 1'b1, "R8 second kept");
    xfer(2'd3, 32'h900, 4'd5, 1'b1, 1'b1, "R8 newcomer held");
  endtask

  task automatic t_r10_backpressure();
    do_reset();
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd2; req_addr = 32'h10; req_ctx = 4'd0;
    @(posedge clk);
    @(negedge clk);
    req_op = 2'd0;
    chk("R10 valid after one cycle", {31'd0, res_valid}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held valid", {31'd0, res_valid}, 32'd1);
      chk("R10 held we", {31'd0, res_we}, 32'd1);
      chk("R10 stall ready", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    t_r11_reset();
    t_r2_empty();
    t_r3_r9();
    t_r1_granule();
    t_r4_clear();
    t_r5_owner();
    t_r6_sweep();
    t_r7_replace();
    t_r8_evict();
    t_r10_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule